// File: doc/BRIEF.md
# Programmable Clock Generator Bank

This block holds a set of clock generators. Each one picks one of several source clocks, divides it by a programmable whole number and drives the result onto a generator clock line. It can also copy that line to a dedicated output pin. A routing table then hands any generator's clock to any numbered peripheral clock channel, and several channels may share one generator. Generator 0 is the one the chip uses as its main system clock, so it comes out of reset already running.

Software configures the bank through one indexed write port. A write word names its target generator or channel and carries the new settings. Settings are not applied the moment they are written. The new values are staged and then cross into the generator's own timing, where they are applied only at the end of an output low phase, so no shortened pulse can appear. A single busy flag covers every staged write. Software polls it, and the bank drops any write that arrives while it is set.

The sources are modelled as ordinary digital clocks. They are oversampled by the fast system clock `clk` through a synchronizer, and every rising and falling source edge found this way counts as one half source period. The divider counts these half periods. That is how an odd divisor can still give an output with a duty cycle within half a source cycle of 50 %.

Top module: `clkgen_bank`

## Requirements
- R1: There are NGEN generators. After reset, generator 0 is enabled on source 0 with divisor 1, duty improvement off and pin output off. Every other generator is disabled with divisor 1.
- R2: A disabled generator holds its clock line low. Disabling a running generator takes effect at the end of its current low phase.
- R3: With effective divisor D, the generator clock has a period of D source periods. A divisor field of 0 or 1 means D = 1, which passes the selected source through at the same shape.
- R4: With duty improvement off and D of 2 or more, the high phase lasts D source half-periods when D is even and D-1 source half-periods when D is odd.
- R5: With duty improvement on, the high phase lasts exactly D source half-periods for any D, so an odd divisor gives a high phase within half a source period of 50 %.
- R6: Any accepted write raises busy_o in the cycle after it is captured. busy_o falls once that write has taken effect, and it never rises without an accepted write.
- R7: A write presented while busy_o is high is ignored and changes no generator or channel.
- R8: gen_pin_o[g] copies gen_clk_o[g], delayed by one cycle, while generator g's pin-output bit is set, and stays low while that bit is clear.
- R9: A routing write sets the generator feeding a channel and the channel's enable bit. An enabled channel outputs its generator's clock one cycle late, several channels may use the same generator, and a disabled or never-routed channel stays low.
- R10: A new source or divisor for a running generator is applied only at the source edge that ends a low phase, so every high and low phase seen around the change has the length of either the old or the new setting.
- R11: Write kind wr_kind_i is 0 for a divider write, 1 for a control write and 2 for a routing write; kind 3 is ignored. In every word bits [7:0] hold the generator number. A divider write puts the divisor at bits [8 +: DIVW]. A control write puts the source at bits [8 +: log2 NSRC], enable at bit 16, duty improvement at bit 17 and pin output at bit 18. A routing write puts the channel number at bits [8 +: log2 NCHAN] and the channel enable at bit 16. A divider write keeps the last control settings, and a control write keeps the last divisor.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; it oversamples the sources |
| rst | input | 1 | Synchronous active-high reset |
| src_clk_i | input | NSRC | Source clocks, one bit per source |
| wr_en_i | input | 1 | Configuration write strobe |
| wr_kind_i | input | 2 | Write kind: divider, control or routing |
| wr_data_i | input | 32 | Configuration write word |
| busy_o | output | 1 | A staged write has not yet taken effect |
| gen_clk_o | output | NGEN | Divided clock of each generator; bit 0 is the main clock |
| gen_pin_o | output | NGEN | Pin copy of each generator clock, gated by its pin-output bit |
| chan_clk_o | output | NCHAN | Peripheral channel clocks from the routing table |

## Verification
The bench builds the bank with NGEN = 8, NSRC = 4, NCHAN = 16 and a 4-bit divisor field. Because the divisor field is only 4 bits wide, the largest divisor (15) and the widest counter value can be reached within short runs. The four sources toggle every 2, 3, 5 and 7 system cycles. Every expected high and low length is therefore an exact multiple of a known half period, and the bench can tell apart the three duty rules for odd divisors, even divisors and divisor 1. Sixteen channels leave room to route two channels to one generator and still keep a channel that is never routed, to confirm it stays silent.

// File: rtl/clkgen_pkg.sv
package clkgen_pkg;

  typedef enum logic [1:0] {
    WR_DIV   = 2'd0,
    WR_CTRL  = 2'd1,
    WR_ROUTE = 2'd2
  } wr_kind_e;

  localparam int WORD_W  = 32;
  localparam int ID_LSB  = 0;
  localparam int FLD_LSB = 8;
  localparam int EN_BIT  = 16;
  localparam int IDC_BIT = 17;
  localparam int OE_BIT  = 18;

endpackage

// File: rtl/clkgen_src_sync.sv
module clkgen_src_sync #(
  parameter int NSRC = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] src_i,
  output logic [NSRC-1:0] edge_o
);

  for (genvar k = 0; k < NSRC; k++) begin : g_src
    logic [2:0] samp;
    always_ff @(posedge clk) begin
      if (rst) samp <= '0;
      else     samp <= {samp[1:0], src_i[k]};
    end
    // any level change of the synchronized source is one half period
    assign edge_o[k] = samp[2] ^ samp[1];
  end

endmodule

// File: rtl/clkgen_div.sv
module clkgen_div #(
  parameter int DIVW   = 8,
  parameter int NSRC   = 4,
  parameter int SRCW   = 2,
  parameter bit RST_EN = 1'b0
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] edge_i,
  input  logic            load_i,
  input  logic [SRCW-1:0] ld_src_i,
  input  logic [DIVW-1:0] ld_div_i,
  input  logic            ld_en_i,
  input  logic            ld_idc_i,
  input  logic            ld_oe_i,
  output logic            clk_o,
  output logic            pin_o,
  output logic            pend_o,
  output logic            en_o
);

  function automatic logic [DIVW-1:0] eff_div(input logic [DIVW-1:0] d);
    return (d == '0) ? DIVW'(1) : d;
  endfunction

  function automatic logic [DIVW:0] period_of(input logic [DIVW-1:0] d);
    return {eff_div(d), 1'b0};
  endfunction

  function automatic logic [DIVW-1:0] high_of(input logic [DIVW-1:0] d, input logic idc);
    logic [DIVW-1:0] e;
    e = eff_div(d);
    if (idc || e == DIVW'(1)) return e;
    return {e[DIVW-1:1], 1'b0};
  endfunction

  // active and staged settings
  logic [SRCW-1:0] a_src, p_src;
  logic [DIVW-1:0] a_div, p_div;
  logic            a_en, a_idc, a_oe, p_en, p_idc, p_oe;
  logic            pend, gclk, pin;
  logic [DIVW:0]   cnt;
  logic            sel_edge;
  logic [DIVW:0]   per_a;
  logic [DIVW-1:0] high_a;

  always_comb begin
    sel_edge = (int'(a_src) < NSRC) ? edge_i[a_src] : 1'b0;
    per_a    = period_of(a_div);
    high_a   = high_of(a_div, a_idc);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      a_src <= '0;  a_div <= DIVW'(1); a_en <= RST_EN; a_idc <= 1'b0; a_oe <= 1'b0;
      p_src <= '0;  p_div <= DIVW'(1); p_en <= 1'b0;   p_idc <= 1'b0; p_oe <= 1'b0;
      pend  <= 1'b0;
      gclk  <= 1'b0;
      pin   <= 1'b0;
      cnt   <= period_of(DIVW'(1)) - 1'b1;
    end else begin
      pin <= gclk & a_oe;
      if (load_i) begin
        p_src <= ld_src_i; p_div <= ld_div_i; p_en <= ld_en_i;
        p_idc <= ld_idc_i; p_oe  <= ld_oe_i;
        pend  <= 1'b1;
      end
      if (pend && !a_en) begin
        // idle generator: apply at once, first edge starts a high phase
        a_src <= p_src; a_div <= p_div; a_en <= p_en; a_idc <= p_idc; a_oe <= p_oe;
        pend  <= 1'b0;
        cnt   <= period_of(p_div) - 1'b1;
        gclk  <= 1'b0;
      end else if (a_en && sel_edge) begin
        if (cnt == per_a - 1'b1) begin
          cnt <= '0;
          if (pend) begin
            a_src <= p_src; a_div <= p_div; a_en <= p_en; a_idc <= p_idc; a_oe <= p_oe;
            pend  <= 1'b0;
            gclk  <= p_en;
          end else begin
            gclk <= 1'b1;
          end
        end else begin
          cnt  <= cnt + 1'b1;
          gclk <= ({1'b0, high_a} > (cnt + 1'b1));
        end
      end
    end
  end

  assign clk_o  = gclk;
  assign pin_o  = pin;
  assign pend_o = pend;
  assign en_o   = a_en;

endmodule

// File: rtl/clkgen_route.sv
module clkgen_route #(
  parameter int NGEN  = 8,
  parameter int NCHAN = 16,
  parameter int GIDW  = 3,
  parameter int CHW   = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_i,
  input  logic [CHW-1:0]   wr_chan_i,
  input  logic [GIDW-1:0]  wr_gen_i,
  input  logic             wr_en_i,
  input  logic [NGEN-1:0]  gen_clk_i,
  output logic [NCHAN-1:0] chan_clk_o,
  output logic             busy_o
);

  logic            rp, r_en;
  logic [CHW-1:0]  r_chan;
  logic [GIDW-1:0] r_gen;
  logic [GIDW-1:0] tbl_gen [NCHAN];
  logic            tbl_en  [NCHAN];

  always_ff @(posedge clk) begin
    if (rst) begin
      rp     <= 1'b0;
      r_en   <= 1'b0;
      r_chan <= '0;
      r_gen  <= '0;
      for (int c = 0; c < NCHAN; c++) begin
        tbl_gen[c] <= '0;
        tbl_en[c]  <= 1'b0;
      end
    end else begin
      rp <= wr_i;
      if (wr_i) begin
        r_chan <= wr_chan_i;
        r_gen  <= wr_gen_i;
        r_en   <= wr_en_i;
      end
      if (rp) begin
        tbl_gen[r_chan] <= r_gen;
        tbl_en[r_chan]  <= r_en;
      end
    end
  end

  for (genvar c = 0; c < NCHAN; c++) begin : g_chan
    always_ff @(posedge clk) begin
      if (rst) chan_clk_o[c] <= 1'b0;
      else     chan_clk_o[c] <= tbl_en[c] & gen_clk_i[tbl_gen[c]];
    end
  end

  assign busy_o = rp;

endmodule

// File: rtl/clkgen_bank.sv
module clkgen_bank
  import clkgen_pkg::*;
#(
  parameter int NGEN  = 8,
  parameter int NSRC  = 4,
  parameter int DIVW  = 8,
  parameter int NCHAN = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NSRC-1:0]   src_clk_i,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_kind_i,
  input  logic [WORD_W-1:0] wr_data_i,
  output logic              busy_o,
  output logic [NGEN-1:0]   gen_clk_o,
  output logic [NGEN-1:0]   gen_pin_o,
  output logic [NCHAN-1:0]  chan_clk_o
);

  localparam int GIDW = $clog2(NGEN);
  localparam int SRCW = $clog2(NSRC);
  localparam int CHW  = $clog2(NCHAN);

  logic [NSRC-1:0] src_edge;
  logic [NGEN-1:0] gen_pend, gen_en_w, gen_load;
  logic            route_busy;

  // field decode
  logic [GIDW-1:0] gid;
  logic [DIVW-1:0] w_div;
  logic [SRCW-1:0] w_src;
  logic [CHW-1:0]  w_chan;
  logic            w_en, w_idc, w_oe;
  logic            acc, is_div, is_ctrl, is_route, gid_ok, chan_ok, gen_wr;
  logic            unused_word;

  assign gid      = wr_data_i[ID_LSB +: GIDW];
  assign w_div    = wr_data_i[FLD_LSB +: DIVW];
  assign w_src    = wr_data_i[FLD_LSB +: SRCW];
  assign w_chan   = wr_data_i[FLD_LSB +: CHW];
  assign w_en     = wr_data_i[EN_BIT];
  assign w_idc    = wr_data_i[IDC_BIT];
  assign w_oe     = wr_data_i[OE_BIT];
  assign unused_word = ^wr_data_i;

  assign busy_o   = (|gen_pend) | route_busy;
  assign acc      = wr_en_i && !busy_o;
  assign is_div   = (wr_kind_i == WR_DIV);
  assign is_ctrl  = (wr_kind_i == WR_CTRL);
  assign is_route = (wr_kind_i == WR_ROUTE);
  assign gid_ok   = int'(gid) < NGEN;
  assign chan_ok  = int'(w_chan) < NCHAN;
  assign gen_wr   = acc && (is_div || is_ctrl) && gid_ok;

  // shadow of the last written settings, merged into each staged load
  logic [SRCW-1:0] sh_src [NGEN];
  logic [DIVW-1:0] sh_div [NGEN];
  logic            sh_en  [NGEN];
  logic            sh_idc [NGEN];
  logic            sh_oe  [NGEN];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int g = 0; g < NGEN; g++) begin
        sh_src[g] <= '0;
        sh_div[g] <= DIVW'(1);
        sh_en[g]  <= (g == 0);
        sh_idc[g] <= 1'b0;
        sh_oe[g]  <= 1'b0;
      end
    end else if (gen_wr) begin
      if (is_div) begin
        sh_div[gid] <= w_div;
      end else begin
        sh_src[gid] <= w_src;
        sh_en[gid]  <= w_en;
        sh_idc[gid] <= w_idc;
        sh_oe[gid]  <= w_oe;
      end
    end
  end

  logic [SRCW-1:0] ld_src;
  logic [DIVW-1:0] ld_div;
  logic            ld_en, ld_idc, ld_oe;

  always_comb begin
    ld_div = is_div ? w_div  : sh_div[gid];
    ld_src = is_div ? sh_src[gid] : w_src;
    ld_en  = is_div ? sh_en[gid]  : w_en;
    ld_idc = is_div ? sh_idc[gid] : w_idc;
    ld_oe  = is_div ? sh_oe[gid]  : w_oe;
  end

  clkgen_src_sync #(.NSRC(NSRC)) u_sync (
    .clk(clk), .rst(rst), .src_i(src_clk_i), .edge_o(src_edge)
  );

  for (genvar g = 0; g < NGEN; g++) begin : g_gen
    assign gen_load[g] = gen_wr && (gid == GIDW'(g));
    clkgen_div #(
      .DIVW(DIVW), .NSRC(NSRC), .SRCW(SRCW), .RST_EN(g == 0)
    ) u_div (
      .clk(clk), .rst(rst), .edge_i(src_edge), .load_i(gen_load[g]),
      .ld_src_i(ld_src), .ld_div_i(ld_div), .ld_en_i(ld_en),
      .ld_idc_i(ld_idc), .ld_oe_i(ld_oe),
      .clk_o(gen_clk_o[g]), .pin_o(gen_pin_o[g]),
      .pend_o(gen_pend[g]), .en_o(gen_en_w[g])
    );
  end

  clkgen_route #(
    .NGEN(NGEN), .NCHAN(NCHAN), .GIDW(GIDW), .CHW(CHW)
  ) u_route (
    .clk(clk), .rst(rst),
    .wr_i(acc && is_route && chan_ok),
    .wr_chan_i(w_chan), .wr_gen_i(gid), .wr_en_i(w_en),
    .gen_clk_i(gen_clk_o), .chan_clk_o(chan_clk_o), .busy_o(route_busy)
  );

endmodule

// File: rtl/clkgen_bank_chk.sv
module clkgen_bank_chk #(
  parameter int NGEN  = 8,
  parameter int NCHAN = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             wr_en_i,
  input logic [1:0]       wr_kind_i,
  input logic [31:0]      wr_data_i,
  input logic             busy_o,
  input logic [NGEN-1:0]  gen_clk_o,
  input logic [NGEN-1:0]  gen_pin_o,
  input logic [NCHAN-1:0] chan_clk_o,
  input logic [NGEN-1:0]  gen_en
);

  localparam int GIDW = $clog2(NGEN);

  assert_busy_set_R6: assert property (@(posedge clk) disable iff (rst)
    (wr_en_i && !busy_o && wr_kind_i == 2'd1 && int'(wr_data_i[GIDW-1:0]) < NGEN) |=> busy_o);

  assert_busy_quiet_R6: assert property (@(posedge clk) disable iff (rst)
    (!busy_o && !wr_en_i) |=> !busy_o);

  for (genvar g = 0; g < NGEN; g++) begin : g_gen_chk
    assert_off_silent_R2: assert property (@(posedge clk) disable iff (rst)
      !gen_en[g] |-> !gen_clk_o[g]);
    assert_pin_follow_R8: assert property (@(posedge clk) disable iff (rst)
      gen_pin_o[g] |-> $past(gen_clk_o[g]));
  end

  for (genvar c = 0; c < NCHAN; c++) begin : g_chan_chk
    assert_chan_source_R9: assert property (@(posedge clk) disable iff (rst)
      chan_clk_o[c] |-> $past(|gen_clk_o));
  end

endmodule

bind clkgen_bank clkgen_bank_chk #(.NGEN(NGEN), .NCHAN(NCHAN)) chk_i (
  .clk(clk), .rst(rst), .wr_en_i(wr_en_i), .wr_kind_i(wr_kind_i),
  .wr_data_i(wr_data_i), .busy_o(busy_o), .gen_clk_o(gen_clk_o),
  .gen_pin_o(gen_pin_o), .chan_clk_o(chan_clk_o), .gen_en(gen_en_w)
);

// File: tb/clkgen_bank_tb_top.sv
module clkgen_bank_tb_top;
  import clkgen_pkg::*;

  localparam int CLK_P = 10;
  localparam int NGEN  = 8;
  localparam int NSRC  = 4;
  localparam int DIVW  = 4;
  localparam int NCHAN = 16;

  logic             clk, rst;
  logic [NSRC-1:0]  src;
  logic             wr_en;
  logic [1:0]       wr_kind;
  logic [31:0]      wr_data;
  logic             busy;
  logic [NGEN-1:0]  gen_clk, gen_pin;
  logic [NCHAN-1:0] chan_clk;

  int nchk = 0, nerr = 0;
  bit done = 0;

  clkgen_bank #(.NGEN(NGEN), .NSRC(NSRC), .DIVW(DIVW), .NCHAN(NCHAN)) dut_i (
    .clk(clk), .rst(rst), .src_clk_i(src), .wr_en_i(wr_en), .wr_kind_i(wr_kind),
    .wr_data_i(wr_data), .busy_o(busy), .gen_clk_o(gen_clk), .gen_pin_o(gen_pin),
    .chan_clk_o(chan_clk)
  );

  initial begin
    clk = 0;
    forever #(CLK_P/2) clk = ~clk;
  end

  // source k toggles every half_of(k) system cycles
  function automatic int half_of(int k);
    case (k)
      0: return 2;
      1: return 3;
      2: return 5;
      default: return 7;
    endcase
  endfunction

  initial begin
    int cnt [NSRC];
    src = '0;
    for (int k = 0; k < NSRC; k++) cnt[k] = 0;
    forever begin
      @(negedge clk);
      for (int k = 0; k < NSRC; k++) begin
        cnt[k]++;
        if (cnt[k] == half_of(k)) begin
          cnt[k] = 0;
          src[k] = ~src[k];
        end
      end
    end
  end

  task automatic check(bit ok, string tag, string what, int act, int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nchk++;
    nerr++;
    $display("FAIL all watchdog expired actual %0d expected %0d", 1, 0);
    finish_run();
  end

  // 0: generator clock, 1: generator pin, 2: channel clock
  function automatic logic probe(int which, int idx);
    case (which)
      0: return gen_clk[idx];
      1: return gen_pin[idx];
      default: return chan_clk[idx];
    endcase
  endfunction

  typedef struct {
    int    which;
    int    idx;
    int    hi;
    int    per;
    string tag;
  } exp_t;
  exp_t sb_q[$];

  task automatic wait_level(int which, int idx, logic val, inout int budget);
    while (probe(which, idx) != val && budget > 0) begin
      @(negedge clk);
      budget--;
    end
  endtask

  task automatic measure(int which, int idx, output int hi, output int per, output bit ok);
    int budget = 3000;
    int h = 0, l = 0;
    wait_level(which, idx, 1'b0, budget);
    wait_level(which, idx, 1'b1, budget);
    wait_level(which, idx, 1'b0, budget);
    wait_level(which, idx, 1'b1, budget);
    while (probe(which, idx) == 1'b1 && budget > 0) begin
      @(negedge clk); h++; budget--;
    end
    while (probe(which, idx) == 1'b0 && budget > 0) begin
      @(negedge clk); l++; budget--;
    end
    hi  = h;
    per = h + l;
    ok  = (budget > 0);
  endtask

  // monitor: pops expected shapes and compares them with what the outputs show
  initial begin
    forever begin
      exp_t e;
      int hi, per;
      bit ok;
      while (sb_q.size() == 0) @(negedge clk);
      e = sb_q[0];
      measure(e.which, e.idx, hi, per, ok);
      check(ok, e.tag, "clock toggles", int'(ok), 1);
      check(hi == e.hi, e.tag, "high cycles", hi, e.hi);
      check(per == e.per, e.tag, "period cycles", per, e.per);
      void'(sb_q.pop_front());
    end
  end

  task automatic expect_shape(int which, int idx, int hi, int per, string tag);
    exp_t e;
    e.which = which; e.idx = idx; e.hi = hi; e.per = per; e.tag = tag;
    sb_q.push_back(e);
    while (sb_q.size() != 0) @(negedge clk);
  endtask

  task automatic check_low(int which, int idx, int n, string tag);
    int seen = 0;
    repeat (n) begin
      @(negedge clk);
      if (probe(which, idx)) seen++;
    end
    check(seen == 0, tag, "cycles high on silent line", seen, 0);
  endtask

  function automatic logic [31:0] div_w(int g, int d);
    return 32'(g) | (32'(d) << FLD_LSB);
  endfunction
  function automatic logic [31:0] ctrl_w(int g, int s, bit en, bit idc, bit oe);
    return 32'(g) | (32'(s) << FLD_LSB) | (32'(en) << EN_BIT) |
           (32'(idc) << IDC_BIT) | (32'(oe) << OE_BIT);
  endfunction
  function automatic logic [31:0] route_w(int g, int c, bit en);
    return 32'(g) | (32'(c) << FLD_LSB) | (32'(en) << EN_BIT);
  endfunction

  task automatic wr(logic [1:0] k, logic [31:0] d);
    @(negedge clk);
    wr_en = 1; wr_kind = k; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic wait_idle();
    int b = 1000;
    while (busy && b > 0) begin
      @(negedge clk); b--;
    end
  endtask

  task automatic watch_runs(int idx, int n, int a, int b, output int runs, output int bad);
    logic prev;
    int len = 0;
    bit first = 1;
    runs = 0; bad = 0;
    prev = gen_clk[idx];
    repeat (n) begin
      @(negedge clk);
      if (gen_clk[idx] == prev) len++;
      else begin
        len++;
        if (!first) begin
          runs++;
          if (len != a && len != b) bad++;
        end
        first = 0;
        len = 0;
        prev = gen_clk[idx];
      end
    end
  endtask

  initial begin
    int runs, bad;
    rst = 1; wr_en = 0; wr_kind = 0; wr_data = 0;
    repeat (5) @(negedge clk);
    rst = 0;
    @(negedge clk);

    // R1 reset state
    check(busy == 1'b0, "R1", "busy after reset", busy, 0);
    check(gen_pin == '0, "R1", "pins after reset", gen_pin, 0);
    check(chan_clk == '0, "R1", "channels after reset", chan_clk, 0);
    expect_shape(0, 0, 2, 4, "R1");           // gen0: source 0, divisor 1
    check_low(0, 7, 40, "R1");

    // R3 / R6: divide by 4 on source 1 (half period 3)
    wr(WR_DIV, div_w(1, 4));
    check(busy == 1'b1, "R6", "busy after write", busy, 1);
    @(negedge clk);
    check(busy == 1'b0, "R6", "busy after idle apply", busy, 0);
    wr(WR_CTRL, ctrl_w(1, 1, 1, 0, 0));
    wait_idle();
    expect_shape(0, 1, 12, 24, "R3");

    // R4: odd divisor without duty improvement, source 2 (half period 5)
    wr(WR_DIV, div_w(2, 3));
    wait_idle();
    wr(WR_CTRL, ctrl_w(2, 2, 1, 0, 0));
    wait_idle();
    expect_shape(0, 2, 10, 30, "R4");
    // R5: duty improvement on the same odd divisor, then on an even one
    wr(WR_CTRL, ctrl_w(2, 2, 1, 1, 0));
    wait_idle();
    expect_shape(0, 2, 15, 30, "R5");
    wr(WR_DIV, div_w(2, 4));
    wait_idle();
    expect_shape(0, 2, 20, 40, "R5");

    // R3: divisor field 0 means passthrough, source 3 (half period 7)
    wr(WR_DIV, div_w(3, 0));
    wait_idle();
    wr(WR_CTRL, ctrl_w(3, 3, 1, 0, 0));
    wait_idle();
    expect_shape(0, 3, 7, 14, "R3");

    // R4: largest divisor 15 on source 0
    wr(WR_DIV, div_w(4, 15));
    wait_idle();
    wr(WR_CTRL, ctrl_w(4, 0, 1, 0, 0));
    wait_idle();
    expect_shape(0, 4, 28, 60, "R4");

    // R7: second write presented while the first is still staged
    @(negedge clk);
    wr_en = 1; wr_kind = WR_DIV; wr_data = div_w(1, 4);
    @(negedge clk);
    check(busy == 1'b1, "R7", "busy during second write", busy, 1);
    wr_kind = WR_CTRL; wr_data = ctrl_w(5, 0, 1, 0, 0);
    @(negedge clk);
    wr_en = 0;
    wait_idle();
    check_low(0, 5, 100, "R7");
    expect_shape(0, 1, 12, 24, "R7");

    // R8: pin silent until its output bit is set
    check_low(1, 1, 60, "R8");
    wr(WR_CTRL, ctrl_w(1, 1, 1, 0, 1));
    wait_idle();
    expect_shape(1, 1, 12, 24, "R8");

    // R9: routing, shared generator, unrouted and disabled channels
    wr(WR_ROUTE, route_w(1, 5, 1));
    wait_idle();
    expect_shape(2, 5, 12, 24, "R9");
    wr(WR_ROUTE, route_w(1, 9, 1));
    wait_idle();
    expect_shape(2, 9, 12, 24, "R9");
    check_low(2, 6, 60, "R9");
    wr(WR_ROUTE, route_w(1, 5, 0));
    wait_idle();
    repeat (2) @(negedge clk);
    check_low(2, 5, 60, "R9");

    // R10: divisor change on a running generator, no runt phase
    fork
      wr(WR_DIV, div_w(1, 2));
      watch_runs(1, 200, 12, 6, runs, bad);
    join
    check(bad == 0, "R10", "phases of foreign length", bad, 0);
    check(runs >= 8, "R10", "phases seen", runs, 8);
    expect_shape(0, 1, 6, 12, "R10");

    // R2: disabling a running generator
    wr(WR_CTRL, ctrl_w(3, 3, 0, 0, 0));
    wait_idle();
    check_low(0, 3, 60, "R2");

    // R11: reserved kind 3 is ignored
    wr(2'd3, ctrl_w(6, 0, 1, 0, 0));
    check(busy == 1'b0, "R11", "busy after reserved kind", busy, 0);
    check_low(0, 6, 40, "R11");

    finish_run();
  end

endmodule